// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects single-cycle event pulses from a serial-bus message engine and turns them into a level interrupt request for a host processor. Each event line has an enable bit in a read/write mask word. An event whose enable bit is set latches a sticky pending bit. An event whose enable bit is clear leaves no trace. The pending bits sit at the same positions as their enable bits in a read-only status word. The top bit of that word is a summary bit, so one read tells the host both that an interrupt is pending and which events caused it.

The host reaches the block over a plain synchronous register port: address, write enable, read enable, 16-bit write data and registered read data. Pending status is never cleared by writing the status word. The host instead writes a separate write-only command word. One command bit drops all pending status. Another command bit returns the whole block to its reset state. The host bus is a simple control port with no data stream, so it has no valid/ready handshake and no back-pressure. A read returns its data one cycle after the request, and the port can take a new access every cycle.

Address map: 0 = mask word (read/write), 1 = status word (read-only), 2 = command word (write-only), 3 to 7 = reserved.

Top module: `irq_status_ctl`

## Requirements
- R1: The mask word at address 0 is read/write. Its reset value is zero. Only bits [N_EVT-1:0] are stored, and all higher bits read as zero.
- R2: An event pulse on evt_i[k] while mask bit k is 1 sets status bit k (address 1). That bit stays set until a clear or a soft reset, even after the pulse ends.
- R3: An event pulse on evt_i[k] while mask bit k is 0 sets no status bit and does not raise irq_o.
- R4: Status bit DATA_W-1 (the summary bit) is 1 exactly when at least one pending bit is set. irq_o is a level output equal to that bit.
- R5: Writing address 2 with bit 0 set clears every pending bit, so irq_o drops in the following cycle. The mask is left unchanged.
- R6: Writing address 2 with bit 1 set returns both the mask and the status to zero. This takes priority over bit 0 and over any event in the same cycle.
- R7: An enabled event in the same cycle as a clear command stays latched after the clear.
- R8: Writes to address 1 have no effect. Reads of address 2 and of addresses 3 to 7 return zero.
- R9: Read data appears on rdata_o in the cycle after rd_en_i and holds until the next read. A mask write affects events starting in the cycle after the write, not events in the same cycle.
- R10: Enabled events that arrive in different cycles accumulate as a bitwise OR in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| evt_i | input | N_EVT | Event pulses, one bit per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and N_EVT = 4, which puts the summary bit at bit 7. At that size all 16 mask values can be swept against all 16 event patterns, so every masked/unmasked pairing is covered and the expected status word can be computed directly as the AND of event and mask plus the summary bit. It then drives the same-cycle cases on top of that sweep: clear against event, soft reset against event and clear, and mask write against event. It also writes the read-only address and reads each reserved address.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned ADR_MASK   = 0;
  localparam int unsigned ADR_STATUS = 1;
  localparam int unsigned ADR_CMD    = 2;
  localparam int unsigned CMD_CLR_BIT  = 0;
  localparam int unsigned CMD_SRST_BIT = 1;

  typedef struct packed {
    logic mask_we;
    logic clr;
    logic srst;
    logic status_wr;
  } cmd_t;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cmd_bits_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o           = '0;
    cmd_o.mask_we   = wr_en_i && (addr_i == ADDR_W'(ADR_MASK));
    cmd_o.status_wr = wr_en_i && (addr_i == ADDR_W'(ADR_STATUS));
    if (wr_en_i && (addr_i == ADDR_W'(ADR_CMD))) begin
      cmd_o.clr  = cmd_bits_i[CMD_CLR_BIT];
      cmd_o.srst = cmd_bits_i[CMD_SRST_BIT];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_EVT = 15
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             we_i,
  input  logic             srst_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    mask_o <= '0;
    else if (srst_i) mask_o <= '0;
    else if (we_i)   mask_o <= wdata_i;
  end

  // R6: soft reset returns the mask to zero
  p_srst_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    srst_i |=> (mask_o == '0));
  // R5: mask only moves on its own write or a soft reset
  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!we_i && !srst_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned N_EVT = 15
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic             clr_i,
  input  logic             srst_i,
  output logic [N_EVT-1:0] pend_o
);
  for (genvar k = 0; k < N_EVT; k++) begin : g_bit
    logic hit;
    assign hit = evt_i[k] & mask_i[k];
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    pend_o[k] <= 1'b0;
      else if (srst_i) pend_o[k] <= 1'b0;
      else if (hit)    pend_o[k] <= 1'b1;
      else if (clr_i)  pend_o[k] <= 1'b0;
    end
  end

  // R3: no pending bit rises without an enabled event
  p_no_masked_set_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(evt_i & mask_i)) == '0));
  // R7: enabled event survives a same-cycle clear
  p_evt_beats_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_i && !srst_i && ((evt_i & mask_i) != '0))
      |=> ((pend_o & $past(evt_i & mask_i)) == $past(evt_i & mask_i)));
  // R5: clear with no enabled event empties the status
  p_clr_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (clr_i && ((evt_i & mask_i) == '0)) |=> (pend_o == '0));
  // R6: soft reset empties the status whatever else happens
  p_srst_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    srst_i |=> (pend_o == '0));
  // R2: pending bits are sticky without clear or reset
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!clr_i && !srst_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_EVT  = 15
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_EVT-1:0]  mask_i,
  input  logic [N_EVT-1:0]  pend_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SUM_BIT = DATA_W - 1;

  logic [DATA_W-1:0] mask_word, stat_word, sel_word;

  always_comb begin
    mask_word              = '0;
    mask_word[N_EVT-1:0]   = mask_i;
    stat_word              = '0;
    stat_word[N_EVT-1:0]   = pend_i;
    stat_word[SUM_BIT]     = |pend_i;
    if (addr_i == ADDR_W'(ADR_MASK))        sel_word = mask_word;
    else if (addr_i == ADDR_W'(ADR_STATUS)) sel_word = stat_word;
    else                                    sel_word = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     rdata_o <= '0;
    else if (rd_en_i) rdata_o <= sel_word;
  end

  // R9: read data holds between reads
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rd_en_i |=> $stable(rdata_o));
  // R8: non-readable addresses give zero
  p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_en_i && (addr_i != ADDR_W'(ADR_MASK)) && (addr_i != ADDR_W'(ADR_STATUS)))
      |=> (rdata_o == '0));
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_EVT  = 15
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o
);
  initial begin
    if (N_EVT < 1 || N_EVT > DATA_W - 1)
      $error("N_EVT must lie in 1..DATA_W-1");
    if (ADDR_W < 2)
      $error("ADDR_W must be at least 2");
  end

  cmd_t             cmd;
  logic [N_EVT-1:0] mask_q;
  logic [N_EVT-1:0] pend_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  irq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .cmd_bits_i(wdata_i[1:0]),
    .cmd_o     (cmd)
  );

  irq_mask_reg #(.N_EVT(N_EVT)) u_mask (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .we_i   (cmd.mask_we),
    .srst_i (cmd.srst),
    .wdata_i(wdata_i[N_EVT-1:0]),
    .mask_o (mask_q)
  );

  irq_pend_latch #(.N_EVT(N_EVT)) u_pend (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .evt_i  (evt_i),
    .mask_i (mask_q),
    .clr_i  (cmd.clr),
    .srst_i (cmd.srst),
    .pend_o (pend_q)
  );

  irq_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT)) u_rd (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .mask_i (mask_q),
    .pend_i (pend_q),
    .rdata_o(rdata_o)
  );

  assign irq_o = |pend_q;

  // R4: interrupt only rises after an enabled event
  p_irq_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(irq_o) |-> ($past(evt_i & mask_q) != '0));
  // R5: clear with no enabled event drops the interrupt
  p_irq_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cmd.clr && ((evt_i & mask_q) == '0)) |=> !irq_o);
  // R8: a status write with no event leaves status untouched
  p_status_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cmd.status_wr && (evt_i == '0)) |=> $stable(pend_q));
endmodule

// File: tb/irq_status_ctl_tb_top.sv
module irq_status_ctl_tb_top;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned NE = 4;
  localparam logic [DW-1:0] SUM = 8'h80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NE-1:0] evt = '0;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  irq_status_ctl #(.ADDR_W(AW), .DATA_W(DW), .N_EVT(NE)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [NE-1:0] e);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1; evt = e;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [DW-1:0] stat_of(input logic [NE-1:0] p);
    return (p != '0) ? (SUM | DW'(p)) : DW'(p);
  endfunction

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(0, rv); check("R1 reset mask", rv, '0);
        rd(1, rv); check("R4 reset status", rv, '0);
        check("R4 reset irq", DW'(irq), '0);

        // exhaustive sweep of mask against event pattern
        for (int m = 0; m < 16; m++) begin
          wr(0, 8'hF0 | 8'(m), '0);
          rd(0, rv); check("R1 mask readback", rv, 8'(m));
          for (int e = 0; e < 16; e++) begin
            logic [NE-1:0] hit;
            hit = NE'(e) & NE'(m);
            pulse(NE'(e));
            check("R3 irq after event", DW'(irq), DW'(hit != '0));
            rd(1, rv); check("R2 status after event", rv, stat_of(hit));
            wr(2, 8'h01, '0);
            check("R5 irq after clear", DW'(irq), '0);
            rd(1, rv); check("R5 status after clear", rv, '0);
          end
          rd(0, rv); check("R5 mask kept by clear", rv, 8'(m));
        end

        // R10 accumulation
        wr(0, 8'h0F, '0);
        pulse(4'h1); pulse(4'h4);
        rd(1, rv); check("R10 accumulate", rv, SUM | 8'h05);

        // R7 event in same cycle as clear
        wr(2, 8'h01, 4'h2);
        rd(1, rv); check("R7 event beats clear", rv, SUM | 8'h02);
        check("R7 irq held", DW'(irq), 8'h01);

        // R8 status write ignored, reserved reads zero
        wr(1, 8'hFF, '0);
        rd(1, rv); check("R8 status write ignored", rv, SUM | 8'h02);
        rd(0, rv); check("R8 mask untouched by status write", rv, 8'h0F);
        for (int a = 2; a < 8; a++) begin
          rd(a, rv); check("R8 write-only/reserved read zero", rv, '0);
        end

        // R9 read data held, mask write timing
        rd(0, rv);
        repeat (3) @(negedge clk);
        check("R9 rdata held", rdata, 8'h0F);
        wr(0, 8'h00, '0);
        wr(2, 8'h01, '0);
        wr(0, 8'h0F, 4'h3);
        rd(1, rv); check("R9 same-cycle mask write uses old mask", rv, '0);
        pulse(4'h3);
        rd(1, rv); check("R9 new mask active next cycle", rv, SUM | 8'h03);

        // R6 soft reset wins over event and clear
        wr(2, 8'h03, 4'h4);
        check("R6 irq after soft reset", DW'(irq), '0);
        rd(1, rv); check("R6 status after soft reset", rv, '0);
        rd(0, rv); check("R6 mask after soft reset", rv, '0);
        pulse(4'hF);
        check("R6 events blocked by reset mask", DW'(irq), '0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule